// File: doc/BRIEF.md
# Four-Channel Unit-Counted DMA Controller

The block is a register-programmed DMA engine with four channels. Each channel has a source address, a destination address, a transfer count and a control word. A single global word holds the master enable and two sticky error flags. The count is held in transfer units, not in bytes. The unit size is picked by a three-bit size code in the control word. Every completed unit decrements the count, advances the addresses that are in use, and sets the channel's transfer-end flag when the count reaches zero.

Units are moved over a plain request/acknowledge memory port, one unit per handshake. The lowest-numbered ready channel wins each handshake. Two misprogramming cases raise the shared address-error flag: writing the address register that a single-address channel does not use, and enabling a channel whose start address is misaligned or whose size code is reserved. An external NMI pulse sets its own flag. Either error clears the master enable and stops every channel. Software clears the flags by writing zeros and restarts by setting the master enable again. Each channel drives a transfer-end interrupt, and the address-error flag drives a shared interrupt.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset every register reads zero, `mem_req` is low and both interrupt outputs are low.
- R2: Control bits 6:4 hold the size code. Code 0 selects 8-byte units, 1 selects 1 byte, 2 selects 2 bytes, 3 selects 4 bytes and 4 selects 32 bytes. The count decrements by one per acknowledged unit. The source and destination registers in use advance by the unit size.
- R3: Control bit 1 (TE) becomes 1 when the last unit is acknowledged, and the channel makes no further requests.
- R4: Control bit 0 is DE and bit 2 is IE. `irq_end[n]` is high exactly while TE and IE of channel n are both 1. Writing 0 to TE clears it, writing 1 leaves it unchanged, and writing IE=0 removes the interrupt.
- R5: No new request starts unless global bit 0 (master enable) is 1 and global bits 1 (NMI flag) and 2 (address error) are both 0.
- R6: Control bits 9:8 select the address mode: 0 is dual, 1 is source-only, 2 is destination-only. A write to the unused address register leaves that register unchanged, sets the address error, clears the master enable and raises `irq_addr_err`, and this halts all transfers.
- R7: Writing 1 to an error flag has no effect and writing 0 clears it. Transfers resume only once the master enable is written to 1 again.
- R8: A high `nmi_in` sets the NMI flag and clears the master enable, which halts all transfers.
- R9: The residue register returns 0 while DE is 0. Otherwise it returns the remaining count shifted left by log2 of the unit size, which is the remaining byte count.
- R10: When DE changes from 0 to 1, a reserved size code (5 to 7) or a used start address that is not a multiple of the unit size sets the address error.
- R11: Among ready channels the lowest index is served first. `mem_req` and its channel, addresses, size and mode stay stable until `mem_ack`, and one unit completes per handshake.
- R12: The count register reads back its current value at any time.

Register map, with `reg_addr` being 5 bits for four channels:
- Bit 4 = 0 selects a channel window. Bits 3:2 give the channel, and bits 1:0 select control (0), source (1), destination (2) or count (3).
- Bit 4 = 1 selects the global window. Bits 1:0 = 0 is the global word. Bits 1:0 = 1 is the residue of the channel given in bits 3:2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational register read data |
| nmi_in | input | 1 | NMI event, sets the NMI flag |
| mem_req | output | 1 | Unit transfer request |
| mem_ack | input | 1 | Unit transfer acknowledge |
| mem_ch | output | 2 | Channel owning the request |
| mem_src | output | 32 | Source address of the unit |
| mem_dst | output | 32 | Destination address of the unit |
| mem_size | output | 3 | Size code of the unit |
| mem_mode | output | 2 | Address mode of the unit |
| irq_end | output | 4 | Per-channel transfer-end interrupts |
| irq_addr_err | output | 1 | Shared address-error interrupt |

## Verification
The bench uses the default parameters: four channels, 32-bit addresses and a 24-bit count. Four channels allow two of them to run alongside each other for the priority check, while a third carries the single-address error case. The 24-bit count lets one channel run long enough that an error or an NMI can be injected in the middle of its transfer. The acknowledge responder answers every request with a single-cycle handshake, so the unit order and the addresses can be logged and compared against counts derived from the size-code table.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  // control word fields
  localparam int CTL_DE    = 0;
  localparam int CTL_TE    = 1;
  localparam int CTL_IE    = 2;
  localparam int CTL_SZ_LO = 4;
  localparam int CTL_MD_LO = 8;

  // global word fields
  localparam int GOP_DME  = 0;
  localparam int GOP_NMIF = 1;
  localparam int GOP_AE   = 2;

  // register indices inside a window
  localparam logic [1:0] IDX_CTL = 2'd0;
  localparam logic [1:0] IDX_SRC = 2'd1;
  localparam logic [1:0] IDX_DST = 2'd2;
  localparam logic [1:0] IDX_CNT = 2'd3;
  localparam logic [1:0] IDX_GOP = 2'd0;
  localparam logic [1:0] IDX_RES = 2'd1;

  typedef enum logic [1:0] {
    MODE_DUAL     = 2'd0,
    MODE_SRC_ONLY = 2'd1,
    MODE_DST_ONLY = 2'd2,
    MODE_RSVD     = 2'd3
  } amode_e;

  // log2 of the unit size for a size code
  function automatic logic [2:0] unit_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 3'd3;
      3'd1:    return 3'd0;
      3'd2:    return 3'd1;
      3'd3:    return 3'd2;
      3'd4:    return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic size_ok(input logic [2:0] code);
    return code <= 3'd4;
  endfunction

  function automatic logic misaligned(input logic [31:0] addr, input logic [2:0] code);
    logic [31:0] mask;
    mask = (32'd1 << unit_shift(code)) - 32'd1;
    return (addr & mask) != 32'd0;
  endfunction

endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_idx,
  input  logic [31:0]   wdata,
  input  logic          unit_done,
  output logic [31:0]   ctrl_rd,
  output logic [31:0]   cnt_rd,
  output logic [31:0]   residue,
  output logic [AW-1:0] src_q,
  output logic [AW-1:0] dst_q,
  output logic [2:0]    size_q,
  output amode_e        mode_q,
  output logic          active,
  output logic          err_evt,
  output logic          irq_end
);

  logic          de_q, te_q, ie_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    sh_q;
  logic [AW-1:0] step;

  logic ctl_wr, src_wr_req, dst_wr_req, cnt_wr, src_wr, dst_wr;
  logic src_unused, dst_unused, bad_addr_wr, de_rise, start_bad, last_unit;
  logic [2:0] new_size;
  amode_e     new_mode;

  assign ctl_wr     = wr_en && (wr_idx == IDX_CTL);
  assign src_wr_req = wr_en && (wr_idx == IDX_SRC);
  assign dst_wr_req = wr_en && (wr_idx == IDX_DST);
  assign cnt_wr     = wr_en && (wr_idx == IDX_CNT);

  assign src_unused  = (mode_q == MODE_DST_ONLY);
  assign dst_unused  = (mode_q == MODE_SRC_ONLY);
  assign src_wr      = src_wr_req && !src_unused;
  assign dst_wr      = dst_wr_req && !dst_unused;
  assign bad_addr_wr = (src_wr_req && src_unused) || (dst_wr_req && dst_unused);

  assign new_size = wdata[CTL_SZ_LO +: 3];
  assign new_mode = amode_e'(wdata[CTL_MD_LO +: 2]);
  assign de_rise  = ctl_wr && wdata[CTL_DE] && !de_q;

  // start-time checks use the incoming size and mode
  assign start_bad = de_rise &&
                     (!size_ok(new_size) ||
                      ((new_mode != MODE_DST_ONLY) && misaligned(32'(src_q), new_size)) ||
                      ((new_mode != MODE_SRC_ONLY) && misaligned(32'(dst_q), new_size)));

  assign err_evt   = bad_addr_wr || start_bad;
  assign last_unit = unit_done && (cnt_q == CW'(1));
  assign sh_q      = unit_shift(size_q);
  assign step      = AW'(1) << sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q   <= 1'b0;
      te_q   <= 1'b0;
      ie_q   <= 1'b0;
      size_q <= 3'd0;
      mode_q <= MODE_DUAL;
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
    end else begin
      if (ctl_wr) begin
        de_q   <= wdata[CTL_DE];
        ie_q   <= wdata[CTL_IE];
        size_q <= new_size;
        mode_q <= new_mode;
        te_q   <= (te_q & wdata[CTL_TE]) | last_unit;
      end else if (last_unit) begin
        te_q <= 1'b1;
      end

      if (src_wr)                           src_q <= wdata[AW-1:0];
      else if (unit_done && !src_unused)    src_q <= src_q + step;

      if (dst_wr)                           dst_q <= wdata[AW-1:0];
      else if (unit_done && !dst_unused)    dst_q <= dst_q + step;

      if (cnt_wr)                           cnt_q <= wdata[CW-1:0];
      else if (unit_done)                   cnt_q <= cnt_q - CW'(1);
    end
  end

  assign active  = de_q && !te_q && (cnt_q != '0) && size_ok(size_q);
  assign irq_end = te_q && ie_q;
  assign ctrl_rd = 32'({mode_q, 1'b0, size_q, 1'b0, ie_q, te_q, de_q});
  assign cnt_rd  = 32'(cnt_q);
  assign residue = de_q ? (32'(cnt_q) << sh_q) : 32'd0;

  assert_count_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cnt_wr) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_te_on_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && (cnt_q == CW'(1))) |=> te_q);

  assert_unused_reg_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_wr_req && dst_unused && !unit_done) |=> $stable(dst_q));

endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] ready,
  output logic [CHW-1:0] pick,
  output logic           any
);

  always_comb begin
    any  = 1'b0;
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (ready[i]) begin
        any  = 1'b1;
        pick = CHW'(i);
      end
    end
  end

endmodule

// File: rtl/dma4_mover.sv
module dma4_mover #(
  parameter int NCH = 4,
  parameter int AW  = 32,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [CHW-1:0] pick,
  input  logic [AW-1:0]  pick_src,
  input  logic [AW-1:0]  pick_dst,
  input  logic [2:0]     pick_size,
  input  logic [1:0]     pick_mode,
  input  logic           mem_ack,
  output logic           mem_req,
  output logic [CHW-1:0] mem_ch,
  output logic [AW-1:0]  mem_src,
  output logic [AW-1:0]  mem_dst,
  output logic [2:0]     mem_size,
  output logic [1:0]     mem_mode,
  output logic [NCH-1:0] unit_done
);

  logic hs;
  assign hs = mem_req && mem_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req  <= 1'b0;
      mem_ch   <= '0;
      mem_src  <= '0;
      mem_dst  <= '0;
      mem_size <= 3'd0;
      mem_mode <= 2'd0;
    end else if (!mem_req) begin
      if (go) begin
        mem_req  <= 1'b1;
        mem_ch   <= pick;
        mem_src  <= pick_src;
        mem_dst  <= pick_dst;
        mem_size <= pick_size;
        mem_mode <= pick_mode;
      end
    end else if (mem_ack) begin
      mem_req <= 1'b0;
    end
  end

  assign unit_done = hs ? (NCH'(1) << mem_ch) : '0;

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_ch) && $stable(mem_src) && $stable(mem_dst)));

  assert_one_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_done));

endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 32,
  parameter int CW  = 24,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int RAW = CHW + 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  input  logic           nmi_in,
  output logic           mem_req,
  input  logic           mem_ack,
  output logic [CHW-1:0] mem_ch,
  output logic [AW-1:0]  mem_src,
  output logic [AW-1:0]  mem_dst,
  output logic [2:0]     mem_size,
  output logic [1:0]     mem_mode,
  output logic [NCH-1:0] irq_end,
  output logic           irq_addr_err
);

  logic           glob_win;
  logic [CHW-1:0] ch_sel;
  logic [1:0]     idx;
  assign glob_win = reg_addr[RAW-1];
  assign ch_sel   = reg_addr[RAW-2:2];
  assign idx      = reg_addr[1:0];

  logic [31:0]   ctrl_a [NCH];
  logic [31:0]   cnt_a  [NCH];
  logic [31:0]   res_a  [NCH];
  logic [AW-1:0] src_a  [NCH];
  logic [AW-1:0] dst_a  [NCH];
  logic [2:0]    size_a [NCH];
  amode_e        mode_a [NCH];
  logic [NCH-1:0] act_vec, err_vec, done_vec;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    dma4_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_wr && !glob_win && (ch_sel == CHW'(g))),
      .wr_idx    (idx),
      .wdata     (reg_wdata),
      .unit_done (done_vec[g]),
      .ctrl_rd   (ctrl_a[g]),
      .cnt_rd    (cnt_a[g]),
      .residue   (res_a[g]),
      .src_q     (src_a[g]),
      .dst_q     (dst_a[g]),
      .size_q    (size_a[g]),
      .mode_q    (mode_a[g]),
      .active    (act_vec[g]),
      .err_evt   (err_vec[g]),
      .irq_end   (irq_end[g])
    );
  end

  // global operation word
  logic dme_q, nmif_q, ae_q, gop_wr, err_any, gate;
  assign gop_wr  = reg_wr && glob_win && (idx == IDX_GOP);
  assign err_any = |err_vec;
  assign gate    = dme_q && !ae_q && !nmif_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dme_q  <= 1'b0;
      nmif_q <= 1'b0;
      ae_q   <= 1'b0;
    end else begin
      logic dme_n, nmif_n, ae_n;
      dme_n  = gop_wr ? reg_wdata[GOP_DME] : dme_q;
      nmif_n = gop_wr ? (nmif_q & reg_wdata[GOP_NMIF]) : nmif_q;
      ae_n   = gop_wr ? (ae_q & reg_wdata[GOP_AE]) : ae_q;
      if (err_any) begin
        ae_n  = 1'b1;
        dme_n = 1'b0;
      end
      if (nmi_in) begin
        nmif_n = 1'b1;
        dme_n  = 1'b0;
      end
      dme_q  <= dme_n;
      nmif_q <= nmif_n;
      ae_q   <= ae_n;
    end
  end

  assign irq_addr_err = ae_q;

  logic [CHW-1:0] pick;
  logic           any;

  dma4_prio #(.NCH(NCH)) u_prio (
    .ready (act_vec),
    .pick  (pick),
    .any   (any)
  );

  dma4_mover #(.NCH(NCH), .AW(AW)) u_mover (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (gate && any),
    .pick      (pick),
    .pick_src  (src_a[pick]),
    .pick_dst  (dst_a[pick]),
    .pick_size (size_a[pick]),
    .pick_mode (mode_a[pick]),
    .mem_ack   (mem_ack),
    .mem_req   (mem_req),
    .mem_ch    (mem_ch),
    .mem_src   (mem_src),
    .mem_dst   (mem_dst),
    .mem_size  (mem_size),
    .mem_mode  (mem_mode),
    .unit_done (done_vec)
  );

  always_comb begin
    reg_rdata = 32'd0;
    if (glob_win) begin
      if (idx == IDX_GOP)      reg_rdata = 32'({ae_q, nmif_q, dme_q});
      else if (idx == IDX_RES) reg_rdata = res_a[ch_sel];
    end else begin
      case (idx)
        IDX_CTL: reg_rdata = ctrl_a[ch_sel];
        IDX_SRC: reg_rdata = 32'(src_a[ch_sel]);
        IDX_DST: reg_rdata = 32'(dst_a[ch_sel]);
        default: reg_rdata = cnt_a[ch_sel];
      endcase
    end
  end

  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(dme_q && !ae_q && !nmif_q));

  assert_lowest_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> (($past(act_vec) & ((NCH'(1) << mem_ch) - NCH'(1))) == '0));

  assert_err_sets_ae_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_any |=> (ae_q && !dme_q));

  assert_nmi_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_in |=> (nmif_q && !dme_q));

endmodule

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        nmi_in = 1'b0;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [1:0]  mem_ch;
  logic [31:0] mem_src, mem_dst;
  logic [2:0]  mem_size;
  logic [1:0]  mem_mode;
  logic [3:0]  irq_end;
  logic        irq_addr_err;

  dma4_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_ch(mem_ch),
    .mem_src(mem_src), .mem_dst(mem_dst), .mem_size(mem_size),
    .mem_mode(mem_mode), .irq_end(irq_end), .irq_addr_err(irq_addr_err)
  );

  always #4 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_flag = 0;

  int          log_n = 0;
  int          log_ch  [0:511];
  logic [31:0] log_src [0:511];
  logic [31:0] log_dst [0:511];

  // stimulus table: size code and byte count
  localparam int NV = 5;
  localparam int VEC_CODE  [NV] = '{1, 2, 3, 0, 4};
  localparam int VEC_BYTES [NV] = '{5, 8, 16, 24, 64};

  function automatic int unit_bytes(input int code);
    case (code)
      0: return 8;
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 32;
      default: return 1;
    endcase
  endfunction

  function automatic logic [4:0] ca(input int ch, input int r);
    return {1'b0, 2'(ch), 2'(r)};
  endfunction
  localparam logic [4:0] A_GOP = 5'b10000;
  function automatic logic [4:0] ra(input int ch);
    return {1'b1, 2'(ch), 2'b01};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done_flag) begin
      done_flag = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // memory responder: one-cycle acknowledge, logs each unit
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        log_ch[log_n]  = int'(mem_ch);
        log_src[log_n] = mem_src;
        log_dst[log_n] = mem_dst;
        log_n = log_n + 1;
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  initial begin
    #1000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    int base, snap;

    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    rd(A_GOP, d);      check("R1 global", d, 0);
    rd(ca(0, 0), d);   check("R1 ctrl0", d, 0);
    rd(ca(3, 3), d);   check("R1 cnt3", d, 0);
    check("R1 mem_req", 32'(mem_req), 0);
    check("R1 irqs", {27'd0, irq_addr_err, irq_end}, 0);

    wr(A_GOP, 32'h1);

    // table walk on channel 0: R2 R3 R4
    for (int v = 0; v < NV; v++) begin
      int ub, units;
      ub = unit_bytes(VEC_CODE[v]);
      units = VEC_BYTES[v] / ub;
      wr(ca(0, 1), 32'h1000);
      wr(ca(0, 2), 32'h4000);
      wr(ca(0, 3), 32'(units));
      base = log_n;
      wr(ca(0, 0), 32'((VEC_CODE[v] << 4) | 5));
      for (int c = 0; c < 400 && !irq_end[0]; c++) @(negedge clk);
      check("R4 irq_end raised", 32'(irq_end[0]), 1);
      idle(6);
      check("R3 unit count, no extra", 32'(log_n - base), 32'(units));
      for (int k = 0; k < units; k++) begin
        check("R2 src step", log_src[base + k], 32'h1000 + 32'(k * ub));
        check("R2 dst step", log_dst[base + k], 32'h4000 + 32'(k * ub));
      end
      rd(ca(0, 3), d); check("R3 count zero", d, 0);
      rd(ca(0, 0), d); check("R3 TE set", d & 32'h2, 32'h2);
      rd(ca(0, 1), d); check("R2 src final", d, 32'h1000 + 32'(VEC_BYTES[v]));
      wr(ca(0, 0), 32'((VEC_CODE[v] << 4) | 3));
      check("R4 IE clear drops irq", 32'(irq_end[0]), 0);
      wr(ca(0, 0), 32'h0);
      rd(ca(0, 0), d); check("R4 TE cleared", d & 32'h2, 0);
    end

    // residue, readback, gating, priority: R9 R12 R5 R11
    wr(A_GOP, 32'h0);
    wr(ca(2, 1), 32'h100);
    wr(ca(2, 2), 32'h200);
    wr(ca(2, 3), 32'd6);
    wr(ca(2, 0), 32'h30);
    rd(ra(2), d);    check("R9 residue DE clear", d, 0);
    wr(ca(2, 0), 32'h31);
    rd(ra(2), d);    check("R9 residue bytes", d, 24);
    rd(ca(2, 3), d); check("R12 count readback", d, 6);
    wr(ca(1, 1), 32'h300);
    wr(ca(1, 2), 32'h400);
    wr(ca(1, 3), 32'd2);
    wr(ca(1, 0), 32'h11);
    base = log_n;
    idle(10);
    check("R5 no start without enable", 32'(log_n - base), 0);
    wr(A_GOP, 32'h1);
    idle(60);
    check("R11 total units", 32'(log_n - base), 8);
    check("R11 first ch1", 32'(log_ch[base]), 1);
    check("R11 second ch1", 32'(log_ch[base + 1]), 1);
    check("R11 then ch2", 32'(log_ch[base + 2]), 2);
    rd(ra(2), d);    check("R9 residue done", d, 0);
    check("R4 no irq without IE", 32'(irq_end[2]), 0);
    wr(ca(1, 0), 32'h0);
    wr(ca(2, 0), 32'h0);
    wr(ca(1, 0), 32'h2);
    rd(ca(1, 0), d); check("R4 TE write one ignored", d & 32'h2, 0);

    // single-address misuse: R6
    wr(ca(3, 0), 32'h110);
    wr(ca(3, 1), 32'h500);
    wr(ca(3, 3), 32'd100);
    base = log_n;
    wr(ca(3, 0), 32'h111);
    idle(10);
    check("R6 running before error", 32'(log_n - base > 0), 1);
    wr(ca(3, 2), 32'h777);
    rd(A_GOP, d);    check("R6 AE set DME clear", d, 32'h4);
    check("R6 irq_addr_err", 32'(irq_addr_err), 1);
    rd(ca(3, 2), d); check("R6 unused reg kept", d, 0);
    idle(4);
    snap = log_n;
    idle(20);
    check("R6 halted", 32'(log_n - snap), 0);
    check("R6 req low", 32'(mem_req), 0);

    // R7 flag clearing and restart
    wr(A_GOP, 32'h7);
    rd(A_GOP, d);    check("R7 write one keeps AE", d, 32'h5);
    idle(10);
    check("R5 blocked by AE", 32'(log_n - snap), 0);
    wr(A_GOP, 32'h0);
    rd(A_GOP, d);    check("R7 AE cleared", d, 0);
    check("R7 irq_addr_err low", 32'(irq_addr_err), 0);
    idle(10);
    check("R7 no resume without DME", 32'(log_n - snap), 0);
    wr(A_GOP, 32'h1);
    idle(10);
    check("R7 resumes", 32'(log_n - snap > 0), 1);

    // R8 NMI halt
    @(negedge clk); nmi_in = 1'b1;
    @(negedge clk); nmi_in = 1'b0;
    rd(A_GOP, d);    check("R8 NMIF set DME clear", d, 32'h2);
    idle(4);
    snap = log_n;
    idle(20);
    check("R8 halted", 32'(log_n - snap), 0);
    wr(A_GOP, 32'h0);
    wr(ca(3, 0), 32'h0);

    // R10 start checks
    wr(A_GOP, 32'h1);
    wr(ca(0, 1), 32'h1002);
    wr(ca(0, 2), 32'h2000);
    wr(ca(0, 3), 32'd2);
    snap = log_n;
    wr(ca(0, 0), 32'h31);
    rd(A_GOP, d);    check("R10 misaligned sets AE", d, 32'h4);
    wr(ca(0, 0), 32'h0);
    wr(A_GOP, 32'h0);
    wr(A_GOP, 32'h1);
    wr(ca(0, 1), 32'h1000);
    wr(ca(0, 0), 32'h51);
    rd(A_GOP, d);    check("R10 reserved size sets AE", d, 32'h4);
    idle(10);
    check("R10 nothing moved", 32'(log_n - snap), 0);
    wr(ca(0, 0), 32'h0);
    wr(A_GOP, 32'h0);

    finish_run();
  end

endmodule